// File: doc/BRIEF.md
# Instruction-Byte Serial Register Port

This block is a serial slave port that lets a host reach a small bank of 24-bit registers. Each exchange is framed by an active-low select. The first eight bits clocked in form a command byte, and data bytes follow it. The command byte carries four things: the transfer direction, a burst length of one to four bytes, which register is the target, and which of its three bytes comes first. Four registers can be written: control, offset trim, upper-range trim and lower-range trim. A fifth register holds the converter result; it can be read but not written. The two range-trim registers share one address, and a bank bit in the command byte picks between them.

Write data always arrives on the shared data line. A mode input chooses where read data goes. In three-wire mode it goes to the separate serial output. In two-wire mode the port drives the shared line itself, once the command byte is complete. All serial inputs pass through a two-stage synchronizer into the system clock, and the port detects the serial clock edges from the synchronized signal. The serial clock half-period must therefore be at least four system clocks. Each tri-state line is split into a data bit and an output-enable bit; an enable of 0 means high impedance.

Top module: `instr_serial_port`

## Requirements
- R1: After synchronous reset, both output enables are 0 and every writable register reads back as 0.
- R2: The command byte is taken MSB first. Bit 7 selects the direction: 1 is a write, 0 is a read. Bits 6:5 hold the byte count minus one. Bits 3:2 select the register: 00 is the result, 01 is control, 10 is offset trim, 11 is range trim. Bits 1:0 give the first byte index, where byte 0 is bits 7:0 and byte 2 is bits 23:16. A start index of 3 is treated as 2.
- R3: Write data is sampled from the shared line on rising serial clock edges, MSB first, in either wire mode. A byte is stored only after all eight of its bits have arrived. If select is lost earlier, the register is unchanged.
- R4: After each full data byte, the byte index steps to the next lower index. After byte 0 it wraps to byte 2.
- R5: Exactly the requested number of bytes is transferred. Further write bits are ignored. On a read, the output is released at the first falling serial clock edge after the last byte.
- R6: With bits 3:2 equal to 11, bit 4 selects the upper-range trim register (0) or the lower-range trim register (1). For all other registers, bit 4 has no effect.
- R7: Writes to the result register are discarded. A read of the result register returns the value that the result input held when the command byte completed, even if the input changes during the burst.
- R8: Read bits are driven after falling serial clock edges, MSB first, starting at the falling edge that follows the command byte. In three-wire mode they appear on the dedicated output. In two-wire mode they appear on the shared line. The other line is never enabled.
- R9: Select going high ends any cycle. Both outputs are released within 3 system clocks, and the next select-low period starts a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from host |
| sclk | input | 1 | Serial clock from host, idle low |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line drive enable (0 = high impedance) |
| sdo_o | output | 1 | Dedicated serial output value |
| sdo_oe | output | 1 | Dedicated serial output enable (0 = high impedance) |
| mode_3wire | input | 1 | 1 = read data on dedicated output, 0 = on shared line |
| conv_data | input | 24 | Current converter result, source of the read-only register |

## Verification
Each serial input takes two synchronizer clocks and one engine clock, so a read bit is valid 3 system clocks after the serial clock falls. The bench holds each serial clock phase for 8 system clocks and samples the outputs at the end of the low phase, just before the next rising edge. A write is stored one clock after the eighth rising edge is detected. The bench therefore checks writes only by reading them back in a later cycle. After a select release, the bench waits 6 clocks before checking the enables, which covers the 3-clock release delay.

// File: rtl/isp_pkg.sv
// Shared types and constants for the instruction-byte serial register port.
package isp_pkg;
    localparam int REG_W    = 24;
    localparam int BYTE_W   = 8;
    localparam int NUM_WR   = 4;
    localparam int CNT_W    = $clog2(BYTE_W);

    // Register selector; SEL_DATA is the read-only result register
    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_OFFS = 3'd2,
        SEL_PFS  = 3'd3,
        SEL_NFS  = 3'd4
    } reg_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_INSTR, ST_WRITE, ST_READ, ST_DONE
    } port_state_t;

    // Byte index after a completed byte: step down, wrap 0 -> 2
    function automatic logic [1:0] next_ptr(input logic [1:0] p);
        return (p == 2'd0) ? 2'd2 : p - 2'd1;
    endfunction
endpackage

// File: rtl/isp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Also provides the previous synchronized value for edge detection.
// Assumes STAGES >= 2 and slowly changing inputs (several clk per level).
module isp_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the inputs through the synchronizer chain and keep one extra copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= {STAGES{RST_VAL}};
            prev_o <= RST_VAL;
        end else begin
            chain  <= {chain[STAGES-2:0], async_i};
            prev_o <= chain[STAGES-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/isp_regbank.sv
// Register bank: four writable 24-bit registers plus a snapshot of the
// converter result. Byte-wide write port, combinational byte read port.
// Assumes wr_ptr / rd_ptr never exceed 2 (the engine guarantees this).
module isp_regbank
    import isp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_t          wr_sel,
    input  logic [1:0]        wr_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              snap,
    input  logic [REG_W-1:0]  conv_data,
    input  reg_sel_t          rd_sel,
    input  logic [1:0]        rd_ptr,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [REG_W-1:0] view [NUM_WR];
    logic [REG_W-1:0] hold;
    logic [REG_W-1:0] word;

    for (genvar i = 0; i < NUM_WR; i++) begin : g_reg
        logic [REG_W-1:0] q;
        // Byte update of writable register i (selector value i+1)
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_sel == reg_sel_t'(i + 1))
                q[BYTE_W*wr_ptr +: BYTE_W] <= wr_data;
        end
        assign view[i] = q;
    end

    // Capture the converter result when a command byte completes
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (snap)
            hold <= conv_data;
    end

    // Select the addressed register for reading
    always_comb begin
        case (rd_sel)
            SEL_DATA: word = hold;
            SEL_CTRL: word = view[0];
            SEL_OFFS: word = view[1];
            SEL_PFS:  word = view[2];
            SEL_NFS:  word = view[3];
            default:  word = '0;
        endcase
    end

    assign rd_byte = word[BYTE_W*rd_ptr +: BYTE_W];
endmodule

// File: rtl/isp_engine.sv
// Protocol engine: collects the command byte, then runs the write or read
// burst with byte-index stepping. Works on synchronized serial signals and
// single-cycle edge strobes. Read bits are updated on serial falling edges.
module isp_engine
    import isp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic              mode_3wire,
    input  logic [BYTE_W-1:0] rd_byte,
    output reg_sel_t          rd_sel,
    output logic [1:0]        rd_ptr,
    output logic              wr_en,
    output reg_sel_t          wr_sel,
    output logic [1:0]        wr_ptr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              snap,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe
);
    port_state_t       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] in_byte;
    logic [1:0]        left;
    logic [1:0]        ptr;
    reg_sel_t          sel;
    reg_sel_t          dec_sel;
    logic              rd_act;
    logic              rd_last;
    logic              last_bit;

    assign in_byte  = {shreg[BYTE_W-2:0], sdi};
    assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));

    // Decode register selector from the completed command byte
    always_comb begin
        case (in_byte[3:2])
            2'b00:   dec_sel = SEL_DATA;
            2'b01:   dec_sel = SEL_CTRL;
            2'b10:   dec_sel = SEL_OFFS;
            default: dec_sel = in_byte[4] ? SEL_NFS : SEL_PFS;
        endcase
    end

    // Main sequencer: command byte, then write or read burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            left    <= '0;
            ptr     <= '0;
            sel     <= SEL_DATA;
            rd_act  <= 1'b0;
            rd_last <= 1'b0;
            wr_en   <= 1'b0;
            wr_sel  <= SEL_DATA;
            wr_ptr  <= '0;
            wr_data <= '0;
            snap    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            snap  <= 1'b0;
            if (!cs_act) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                rd_act  <= 1'b0;
                rd_last <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        state   <= ST_INSTR;
                        bit_cnt <= '0;
                    end
                    ST_INSTR: if (sclk_rise) begin
                        shreg   <= in_byte;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            sel   <= dec_sel;
                            ptr   <= (in_byte[1:0] == 2'd3) ? 2'd2 : in_byte[1:0];
                            left  <= in_byte[6:5];
                            snap  <= 1'b1;
                            state <= in_byte[7] ? ST_WRITE : ST_READ;
                        end
                    end
                    ST_WRITE: if (sclk_rise) begin
                        shreg   <= in_byte;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            wr_en   <= (sel != SEL_DATA);
                            wr_sel  <= sel;
                            wr_ptr  <= ptr;
                            wr_data <= in_byte;
                            ptr     <= next_ptr(ptr);
                            if (left == 2'd0) state <= ST_DONE;
                            else              left  <= left - 1'b1;
                        end
                    end
                    ST_READ: if (sclk_fall) begin
                        if (bit_cnt == '0 && rd_last) begin
                            state  <= ST_DONE;
                            rd_act <= 1'b0;
                        end else begin
                            if (bit_cnt == '0) begin
                                shreg  <= rd_byte;
                                rd_act <= 1'b1;
                            end else begin
                                shreg <= shreg << 1;
                            end
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                ptr <= next_ptr(ptr);
                                if (left == 2'd0) rd_last <= 1'b1;
                                else              left    <= left - 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_sel  = sel;
    assign rd_ptr  = ptr;
    assign sdio_oe = rd_act & ~mode_3wire;
    assign sdo_oe  = rd_act &  mode_3wire;
    assign sdio_o  = sdio_oe & shreg[BYTE_W-1];
    assign sdo_o   = sdo_oe  & shreg[BYTE_W-1];
endmodule

// File: rtl/instr_serial_port.sv
// Top of the instruction-byte serial register port. Synchronizes the serial
// pins into clk, derives serial clock edge strobes, and connects the protocol
// engine to the register bank. Assumes sclk half-period >= 4 clk cycles.
module instr_serial_port
    import isp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdio_i,
    output logic             sdio_o,
    output logic             sdio_oe,
    output logic             sdo_o,
    output logic             sdo_oe,
    input  logic             mode_3wire,
    input  logic [REG_W-1:0] conv_data
);
    logic [2:0]        pin_sync;
    logic [2:0]        pin_prev;
    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic [BYTE_W-1:0] rd_byte;
    reg_sel_t          rd_sel;
    logic [1:0]        rd_ptr;
    logic              wr_en;
    reg_sel_t          wr_sel;
    logic [1:0]        wr_ptr;
    logic [BYTE_W-1:0] wr_data;
    logic              snap;

    isp_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, sdio_i}),
        .sync_o  (pin_sync),
        .prev_o  (pin_prev)
    );

    assign cs_act    = ~pin_sync[2];
    assign sclk_rise =  pin_sync[1] & ~pin_prev[1];
    assign sclk_fall = ~pin_sync[1] &  pin_prev[1];

    isp_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .sdi        (pin_sync[0]),
        .mode_3wire (mode_3wire),
        .rd_byte    (rd_byte),
        .rd_sel     (rd_sel),
        .rd_ptr     (rd_ptr),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_ptr     (wr_ptr),
        .wr_data    (wr_data),
        .snap       (snap),
        .sdio_o     (sdio_o),
        .sdio_oe    (sdio_oe),
        .sdo_o      (sdo_o),
        .sdo_oe     (sdo_oe)
    );

    isp_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .snap      (snap),
        .conv_data (conv_data),
        .rd_sel    (rd_sel),
        .rd_ptr    (rd_ptr),
        .rd_byte   (rd_byte)
    );
endmodule

// File: rtl/isp_port_checker.sv
// Protocol checker for instr_serial_port, attached with bind.
// Keeps a saturating count of cycles since reset so no $past reaches
// back before reset.
module isp_port_checker
    import isp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdio_oe,
    input logic       sdo_oe,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic       sclk_rise
);
    logic [2:0] since_rst;

    // Count cycles since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 3'd7)
            since_rst <= since_rst + 1'b1;
    end

    AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe)); // R8

    AST_NO_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_sel != SEL_DATA)); // R7

    AST_COMMIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && wr_en) |-> $past(sclk_rise)); // R3

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> (!sdio_oe && !sdo_oe)); // R9

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && (sdio_oe || sdo_oe)) |-> !$past(cs_n, 3)); // R9
endmodule

bind instr_serial_port isp_port_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdio_oe   (sdio_oe),
    .sdo_oe    (sdo_oe),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .sclk_rise (sclk_rise)
);

// File: tb/instr_serial_port_bench.sv
// Directed bench for instr_serial_port: one task per scenario.
module instr_serial_port_bench;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdio_i = 1'b0;
    logic        mode_3wire = 1'b1;
    logic [23:0] conv_data = 24'h0;
    logic        sdio_o, sdio_oe, sdo_o, sdo_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    instr_serial_port u_instr_serial_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdio_i     (sdio_i),
        .sdio_o     (sdio_o),
        .sdio_oe    (sdio_oe),
        .sdo_o      (sdo_o),
        .sdo_oe     (sdo_oe),
        .mode_3wire (mode_3wire),
        .conv_data  (conv_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ins(input bit wr, input int n, input bit bank,
                                       input logic [1:0] reg_a, input logic [1:0] start);
        logic [1:0] cnt;
        cnt = 2'(n - 1);
        return {wr, cnt, bank, reg_a, start};
    endfunction

    task automatic start_cycle();
        sclk = 1'b0;
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic end_cycle();
        sclk = 1'b0;
        tick(2);
        cs_n = 1'b1;
        tick(8);
    endtask

    // One byte: drive w on the shared line, sample both outputs before each rise
    task automatic xbyte(input logic [7:0] w, output logic [7:0] r,
                         output bit line_ok);
        line_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            sdio_i = w[i];
            tick(H);
            if (mode_3wire) begin
                r[i] = sdo_o;
                if (!sdo_oe || sdio_oe) line_ok = 1'b0;
            end else begin
                r[i] = sdio_o;
                if (!sdio_oe || sdo_oe) line_ok = 1'b0;
            end
            sclk = 1'b1;
            tick(H);
        end
    endtask

    task automatic write_burst(input logic [7:0] cmd, input logic [31:0] d, input int n);
        logic [7:0] r;
        bit ok;
        start_cycle();
        xbyte(cmd, r, ok);
        for (int k = 0; k < n; k++)
            xbyte(d[8*(n-1-k) +: 8], r, ok);
        end_cycle();
    endtask

    task automatic read_burst(input string req, input logic [7:0] cmd, input int n,
                              input logic [31:0] exp);
        logic [7:0]  r;
        logic [31:0] acc;
        bit ok, all_ok;
        acc = '0;
        all_ok = 1'b1;
        start_cycle();
        xbyte(cmd, r, ok);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, r, ok);
            acc = {acc[23:0], r};
            all_ok = all_ok & ok;
        end
        check(req, "read data", acc, exp);
        check("R8", "read line enables per mode", 32'(all_ok), 32'd1);
        sclk = 1'b0;
        tick(H);
        check("R5", "release after last byte", {30'd0, sdio_oe, sdo_oe}, 32'd0);
        end_cycle();
    endtask

    task automatic t_reset();
        check("R1", "enables after reset", {30'd0, sdio_oe, sdo_oe}, 32'd0);
        read_burst("R1", ins(0, 3, 0, 2'b01, 2'd2), 3, 32'h000000);
        read_burst("R1", ins(0, 3, 1, 2'b11, 2'd2), 3, 32'h000000);
    endtask

    task automatic t_write_read_3wire();
        mode_3wire = 1'b1;
        write_burst(ins(1, 3, 0, 2'b01, 2'd2), 32'hA5C33C, 3);
        read_burst("R2", ins(0, 3, 0, 2'b01, 2'd2), 3, 32'hA5C33C);
    endtask

    task automatic t_two_wire();
        mode_3wire = 1'b0;
        read_burst("R8", ins(0, 3, 0, 2'b01, 2'd2), 3, 32'hA5C33C);
        write_burst(ins(1, 1, 0, 2'b10, 2'd0), 32'h5A, 1);
        read_burst("R3", ins(0, 3, 0, 2'b10, 2'd2), 3, 32'h00005A);
        mode_3wire = 1'b1;
    endtask

    task automatic t_wrap();
        read_burst("R4", ins(0, 4, 0, 2'b01, 2'd2), 4, 32'hA5C33CA5);
        read_burst("R4", ins(0, 2, 0, 2'b01, 2'd0), 2, 32'h3CA5);
        read_burst("R2", ins(0, 1, 0, 2'b01, 2'd3), 1, 32'hA5);
    endtask

    task automatic t_bank();
        write_burst(ins(1, 3, 0, 2'b11, 2'd2), 32'h123456, 3);
        write_burst(ins(1, 3, 1, 2'b11, 2'd2), 32'hFEDCBA, 3);
        read_burst("R6", ins(0, 3, 0, 2'b11, 2'd2), 3, 32'h123456);
        read_burst("R6", ins(0, 3, 1, 2'b11, 2'd2), 3, 32'hFEDCBA);
        read_burst("R6", ins(0, 3, 1, 2'b01, 2'd2), 3, 32'hA5C33C);
    endtask

    task automatic t_data_ro();
        logic [7:0]  r;
        logic [31:0] acc;
        bit ok;
        conv_data = 24'h9ABCDE;
        write_burst(ins(1, 3, 0, 2'b00, 2'd2), 32'hFFFFFF, 3);
        read_burst("R7", ins(0, 3, 0, 2'b00, 2'd2), 3, 32'h9ABCDE);
        read_burst("R7", ins(0, 3, 0, 2'b01, 2'd2), 3, 32'hA5C33C);
        acc = '0;
        start_cycle();
        xbyte(ins(0, 3, 0, 2'b00, 2'd2), r, ok);
        conv_data = 24'h000000;
        for (int k = 0; k < 3; k++) begin
            xbyte(8'h00, r, ok);
            acc = {acc[23:0], r};
        end
        end_cycle();
        check("R7", "snapshot held during burst", acc, 32'h9ABCDE);
    endtask

    task automatic t_burst_len();
        logic [7:0] r;
        bit ok;
        start_cycle();
        xbyte(ins(1, 1, 0, 2'b01, 2'd1), r, ok);
        xbyte(8'h77, r, ok);
        xbyte(8'h88, r, ok);
        end_cycle();
        read_burst("R5", ins(0, 3, 0, 2'b01, 2'd2), 3, 32'hA5773C);
    endtask

    task automatic t_abort_write();
        logic [7:0] r;
        bit ok;
        start_cycle();
        xbyte(ins(1, 1, 0, 2'b10, 2'd0), r, ok);
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b0; sdio_i = 1'b1; tick(H);
            sclk = 1'b1; tick(H);
        end
        end_cycle();
        check("R9", "enables after write abort", {30'd0, sdio_oe, sdo_oe}, 32'd0);
        read_burst("R3", ins(0, 3, 0, 2'b10, 2'd2), 3, 32'h00005A);
    endtask

    task automatic t_abort_read();
        logic [7:0] r;
        bit ok;
        start_cycle();
        xbyte(ins(0, 3, 0, 2'b01, 2'd2), r, ok);
        xbyte(8'h00, r, ok);
        sclk = 1'b0;
        tick(H);
        check("R8", "enable mid burst", {30'd0, sdio_oe, sdo_oe}, 32'd1);
        cs_n = 1'b1;
        tick(6);
        check("R9", "enables after read abort", {30'd0, sdio_oe, sdo_oe}, 32'd0);
        tick(4);
        read_burst("R9", ins(0, 2, 0, 2'b01, 2'd1), 2, 32'h773C);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_write_read_3wire();
        t_two_wire();
        t_wrap();
        t_bank();
        t_data_ro();
        t_burst_len();
        t_abort_write();
        t_abort_read();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule